// File: doc/BRIEF.md
# Caller-ID Receiver Mode and Interrupt Controller

This block sits between the detectors of a caller-ID receiver and the host microcontroller. Two mode pins select one of three operating modes: tone-alert detect, FSK receive, and a zero-power sleep. The selected mode decides which detector event reaches the detect output and which events may pull the active-low interrupt output. The mode also switches on the FSK path, the tone path and the clock.

In tone-alert mode, the interrupt fires when a dual-tone alert ends, not when it starts. The interrupt then stays latched until the controller leaves tone mode. In the two active modes, the ring/polarity-reversal flag is asynchronous, so it passes through a flop synchronizer first. In zero-power mode no clock runs, so that flag drives both outputs directly through combinational logic.

Top module: `cid_mode_ctrl`

## Requirements
- R1: The mode pins decode as follows. pwr_save_i=1 selects zero-power, whatever sel_fsk_i is. pwr_save_i=0 with sel_fsk_i=0 selects tone-alert mode. pwr_save_i=0 with sel_fsk_i=1 selects FSK receive. tone_en_o is 1 only in tone-alert mode, and fsk_en_o is 1 only in FSK receive. clk_en_o is 1 in both active modes and 0 in zero-power.
- R2: In tone-alert mode, det_o equals tone_ok_i in the same cycle.
- R3: In FSK receive mode, det_o equals lvl_ok_i in the same cycle.
- R4: In zero-power mode, det_o equals ring_async_i and irq_n_o equals its inverse. Both follow combinationally, with no clock edge needed.
- R5: In the active modes, ring_async_i passes through a SYNC_STAGES-flop synchronizer (default 2). With the default, irq_n_o goes low after the second rising clock edge that samples ring high, and returns high after the second edge that samples it low.
- R6: In FSK receive mode, retime_irq_i=1 drives irq_n_o low in the same cycle.
- R7: In tone-alert mode, a fall of tone_ok_i latches irq_n_o low from the next rising edge. The latch holds even if tone_ok_i rises again.
- R8: The tone-end latch clears on the first rising edge at which the decoded mode is not tone-alert. After returning to tone-alert mode, irq_n_o is high unless a new event occurs.
- R9: In tone-alert mode, a rise of tone_ok_i does not pull irq_n_o low. retime_irq_i and lvl_ok_i have no effect on either output in this mode.
- R10: A fall of tone_ok_i that coincides with the first cycle of tone-alert mode is not latched. Only falls seen while tone mode was already selected on the previous edge count.
- R11: After reset, with quiet inputs, irq_n_o is high and no tone-end interrupt is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock, running in the active modes |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_save_i | input | 1 | Zero-power select pin |
| sel_fsk_i | input | 1 | Selects FSK receive (1) or tone-alert (0) when awake |
| ring_async_i | input | 1 | Ring/polarity-reversal detect, asynchronous |
| tone_ok_i | input | 1 | Dual-tone alert currently valid |
| lvl_ok_i | input | 1 | FSK carrier level above threshold |
| retime_irq_i | input | 1 | Character-ready request from the data retimer |
| det_o | output | 1 | Detect output for the selected mode |
| irq_n_o | output | 1 | Active-low interrupt/wake-up |
| fsk_en_o | output | 1 | FSK path enable |
| tone_en_o | output | 1 | Tone path enable |
| clk_en_o | output | 1 | Oscillator/clock enable |

## Verification
The bench sweeps all four mode-pin codes against every combination of the tone, level and retimer flags. This separates which flag each mode routes to the detect output and to the interrupt, and shows that the other flags have no effect. The ring flag is tried in two ways: raw in zero-power, where an immediate response is expected, and stepped across clock edges in FSK mode, where the synchronizer delay must show. Directed tone sequences then tell a tone rise apart from a tone fall, and test whether the latch holds through a tone that comes back. They also check that the latch clears when the mode leaves tone-alert, and that a fall coinciding with mode entry is not latched.

// File: rtl/cid_ctrl_pkg.sv
package cid_ctrl_pkg;
   typedef enum logic [1:0] {
      CM_TONE  = 2'd0,
      CM_FSK   = 2'd1,
      CM_SLEEP = 2'd2
   } cid_mode_e;
endpackage

// File: rtl/cid_mode_decode.sv
module cid_mode_decode
   import cid_ctrl_pkg::*;
(
   input  logic      pwr_save_i,
   input  logic      sel_fsk_i,
   output cid_mode_e mode_o,
   output logic      fsk_en_o,
   output logic      tone_en_o,
   output logic      clk_en_o
);
   always_comb begin
      if (pwr_save_i)     mode_o = CM_SLEEP;
      else if (sel_fsk_i) mode_o = CM_FSK;
      else                mode_o = CM_TONE;
   end

   assign fsk_en_o  = (mode_o == CM_FSK);
   assign tone_en_o = (mode_o == CM_TONE);
   assign clk_en_o  = (mode_o != CM_SLEEP);
endmodule

// File: rtl/cid_ring_sync.sv
module cid_ring_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("cid_ring_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cid_tone_end_latch.sv
module cid_tone_end_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic tone_mode_i,
   input  logic tone_ok_i,
   output logic hold_o
);
   logic tone_q;
   logic mode_q;
   logic hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tone_q <= 1'b0;
         mode_q <= 1'b0;
         hold_q <= 1'b0;
      end else begin
         tone_q <= tone_ok_i;
         mode_q <= tone_mode_i;
         if (!tone_mode_i)
            hold_q <= 1'b0;
         else if (mode_q && tone_q && !tone_ok_i)
            hold_q <= 1'b1;
      end
   end

   assign hold_o = hold_q;
endmodule

// File: rtl/cid_mode_ctrl.sv
module cid_mode_ctrl
   import cid_ctrl_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_save_i,
   input  logic sel_fsk_i,
   input  logic ring_async_i,
   input  logic tone_ok_i,
   input  logic lvl_ok_i,
   input  logic retime_irq_i,
   output logic det_o,
   output logic irq_n_o,
   output logic fsk_en_o,
   output logic tone_en_o,
   output logic clk_en_o
);
   cid_mode_e mode;
   logic      ring_s;
   logic      tone_hold;

   cid_mode_decode u_dec (
      .pwr_save_i (pwr_save_i),
      .sel_fsk_i  (sel_fsk_i),
      .mode_o     (mode),
      .fsk_en_o   (fsk_en_o),
      .tone_en_o  (tone_en_o),
      .clk_en_o   (clk_en_o)
   );

   cid_ring_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (ring_async_i),
      .q_o   (ring_s)
   );

   cid_tone_end_latch u_latch (
      .clk         (clk),
      .rst_n       (rst_n),
      .tone_mode_i (tone_en_o),
      .tone_ok_i   (tone_ok_i),
      .hold_o      (tone_hold)
   );

   always_comb begin
      unique case (mode)
         CM_TONE: begin
            det_o   = tone_ok_i;
            irq_n_o = ~(tone_hold | ring_s);
         end
         CM_FSK: begin
            det_o   = lvl_ok_i;
            irq_n_o = ~(retime_irq_i | ring_s);
         end
         default: begin
            det_o   = ring_async_i;
            irq_n_o = ~ring_async_i;
         end
      endcase
   end
endmodule

// File: rtl/cid_mode_ctrl_chk.sv
module cid_mode_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic pwr_save_i,
   input logic ring_async_i,
   input logic tone_ok_i,
   input logic lvl_ok_i,
   input logic det_o,
   input logic irq_n_o,
   input logic fsk_en_o,
   input logic tone_en_o,
   input logic clk_en_o,
   input logic hold_q
);
   logic warm_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) warm_q <= 1'b0;
      else        warm_q <= 1'b1;
   end

   // R1
   path_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fsk_en_o, tone_en_o}));

   // R1
   sleep_clock_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_save_i |-> (!clk_en_o && !fsk_en_o && !tone_en_o));

   // R3
   fsk_det_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fsk_en_o |-> (det_o == lvl_ok_i));

   // R4
   sleep_ring_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_save_i |-> (det_o == ring_async_i && irq_n_o == !ring_async_i));

   // R7
   tone_end_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q && tone_en_o && $past(tone_en_o) && $past(tone_ok_i) && !tone_ok_i)
      |=> (!tone_en_o || !irq_n_o));

   // R8
   latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tone_en_o |=> !hold_q);
endmodule

bind cid_mode_ctrl cid_mode_ctrl_chk chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .pwr_save_i   (pwr_save_i),
   .ring_async_i (ring_async_i),
   .tone_ok_i    (tone_ok_i),
   .lvl_ok_i     (lvl_ok_i),
   .det_o        (det_o),
   .irq_n_o      (irq_n_o),
   .fsk_en_o     (fsk_en_o),
   .tone_en_o    (tone_en_o),
   .clk_en_o     (clk_en_o),
   .hold_q       (tone_hold)
);

// File: tb/cid_mode_ctrl_tb_top.sv
module cid_mode_ctrl_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic zp = 1'b0, md = 1'b0, ring = 1'b0, tone = 1'b0, lvl = 1'b0, rt = 1'b0;
   logic det, irq_n, fsk_en, tone_en, clk_en;
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done = 1'b0;

   always #5 clk = ~clk;

   cid_mode_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .pwr_save_i(zp), .sel_fsk_i(md),
      .ring_async_i(ring), .tone_ok_i(tone), .lvl_ok_i(lvl), .retime_irq_i(rt),
      .det_o(det), .irq_n_o(irq_n), .fsk_en_o(fsk_en), .tone_en_o(tone_en),
      .clk_en_o(clk_en)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic drive(input logic z, input logic m, input logic r,
                        input logic t, input logic l, input logic q);
      @(negedge clk);
      zp = z; md = m; ring = r; tone = t; lvl = l; rt = q;
      #2;
   endtask

   task automatic edge_pass();
      @(posedge clk);
      #2;
   endtask

   initial begin
      #100000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // R11 reset state
      chk("R11 irq_n in reset", irq_n, 1'b1);
      @(negedge clk) rst_n = 1'b1;
      edge_pass();
      chk("R11 irq_n after reset", irq_n, 1'b1);

      // Sweep: zero-power codes, then FSK, all flag combinations
      for (int c = 0; c < 64; c++) begin
         logic z, m, r, t, l, q;
         z = 1'b1; m = c[5]; r = c[4]; t = c[2]; l = c[1]; q = c[0];
         if (c[3]) continue;
         drive(z, m, r, t, l, q);
         // R1
         chk("R1 fsk_en sleep", fsk_en, 1'b0);
         chk("R1 tone_en sleep", tone_en, 1'b0);
         chk("R1 clk_en sleep", clk_en, 1'b0);
         // R4
         chk("R4 det sleep", det, r);
         chk("R4 irq_n sleep", irq_n, ~r);
      end
      drive(0, 1, 0, 0, 0, 0);
      repeat (3) edge_pass();
      for (int c = 0; c < 8; c++) begin
         drive(0, 1, 0, c[2], c[1], c[0]);
         chk("R1 fsk_en fsk", fsk_en, 1'b1);
         chk("R1 tone_en fsk", tone_en, 1'b0);
         chk("R1 clk_en fsk", clk_en, 1'b1);
         chk("R3 det fsk", det, c[1]);
         chk("R6 irq_n fsk", irq_n, ~c[0]);
      end
      // Tone sweep: tone held low then high (rises only)
      drive(1, 0, 0, 0, 0, 0);
      edge_pass();
      for (int c = 0; c < 8; c++) begin
         drive(0, 0, 0, c[2], c[1], c[0]);
         edge_pass();
         chk("R1 tone_en tone", tone_en, 1'b1);
         chk("R1 fsk_en tone", fsk_en, 1'b0);
         chk("R1 clk_en tone", clk_en, 1'b1);
         chk("R2 det tone", det, c[2]);
         chk("R9 irq_n tone unaffected", irq_n, 1'b1);
      end

      // R5 synchronizer latency in FSK mode
      drive(0, 1, 0, 0, 0, 0);
      repeat (3) edge_pass();
      drive(0, 1, 1, 0, 0, 0);
      chk("R5 irq_n before first edge", irq_n, 1'b1);
      edge_pass();
      chk("R5 irq_n after one edge", irq_n, 1'b1);
      edge_pass();
      chk("R5 irq_n after two edges", irq_n, 1'b0);
      drive(0, 1, 0, 0, 0, 0);
      edge_pass();
      chk("R5 release after one edge", irq_n, 1'b0);
      edge_pass();
      chk("R5 release after two edges", irq_n, 1'b1);

      // R7 tone-end latch
      drive(0, 0, 0, 1, 0, 0);
      repeat (2) edge_pass();
      chk("R9 tone rise no irq", irq_n, 1'b1);
      drive(0, 0, 0, 0, 0, 0);
      chk("R7 det low on fall", det, 1'b0);
      chk("R7 irq_n before edge", irq_n, 1'b1);
      edge_pass();
      chk("R7 irq_n latched", irq_n, 1'b0);
      drive(0, 0, 0, 1, 1, 0);
      edge_pass();
      chk("R7 latch holds on tone return", irq_n, 1'b0);
      chk("R2 det tone return", det, 1'b1);
      drive(0, 0, 0, 1, 0, 1);
      edge_pass();
      chk("R9 retime ignored in tone", irq_n, 1'b0);

      // R8 leave tone mode clears latch
      drive(0, 1, 0, 1, 0, 0);
      chk("R8 irq_n in fsk", irq_n, 1'b1);
      edge_pass();
      drive(0, 0, 0, 1, 0, 0);
      edge_pass();
      chk("R8 irq_n back in tone", irq_n, 1'b1);
      edge_pass();
      chk("R8 irq_n stays clear", irq_n, 1'b1);

      // R10 fall coinciding with tone entry is not latched
      drive(0, 1, 0, 1, 0, 0);
      repeat (2) edge_pass();
      drive(0, 0, 0, 0, 0, 0);
      repeat (2) edge_pass();
      chk("R10 entry fall ignored", irq_n, 1'b1);

      // R4 in sleep with the latch set before
      drive(0, 0, 0, 1, 0, 0);
      repeat (2) edge_pass();
      drive(0, 0, 0, 0, 0, 0);
      edge_pass();
      chk("R7 second latch", irq_n, 1'b0);
      drive(1, 1, 0, 0, 0, 0);
      chk("R4 sleep ignores latch", irq_n, 1'b1);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule